// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Slave

This block is the slave end of a synchronous host bus. An external processor uses it to read and write a small internal register file. The bus has an 8-bit address, an active-low select and an active-low address strobe. It also has separate active-low read and write strobes. The bidirectional data bus is split into an input, an output and an output enable, and a pacing output tells the processor when to wait. A static mode pin sets the select condition: either the select line alone, or the select line and the address strobe together.

An access runs through a fixed order of bus states, and both clock edges are used. The address is latched on the rising edge that leaves idle. The read strobe is sampled on the falling edge that follows, and read data is put on the bus at the next rising edge. The write strobe is sampled on a rising edge, and the write data is stored on the falling edge after it. Releasing the strobe ends the cycle. Releasing the select condition returns the block to idle.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, and whenever the select condition is not met, the wait output is 1, the data output enable is 0 and every register reads 0.
- R2: With addr_mode_i = 0, select low alone starts an access, whatever the state of the address strobe.
- R3: With addr_mode_i = 1, no access starts while the address strobe is high, even with select and a strobe low: wait stays 1 and the data output stays disabled.
- R4: A read strobe that is low at the falling edge after address capture enables the output at the next rising edge, carrying the addressed register. Wait is 0 in the address phase and 1 once the data is driven.
- R5: Holding the read strobe low keeps the same data driven for as many cycles as it is held.
- R6: The rising edge after the read strobe is seen high disables the output, and wait reads 1.
- R7: A write strobe seen low at the rising edge after address capture stores data_i into the addressed register on the following falling edge. Wait is 0 until that edge and 1 after it.
- R8: A write ends when the write strobe returns high, and the stored value is then readable.
- R9: When both strobes are low together, nothing is written, the output is never enabled and wait stays 0.
- R10: Addresses of 16 and above read as 0, and writes to them change no register.
- R11: The address is taken on the rising edge that leaves idle. Changes on addr_i later in the same access have no effect.
- R12: Releasing the select condition during a stretched read disables the output at the next rising edge, and the next access works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_mode_i | input | 1 | 0: select alone, 1: select and address strobe |
| addr_i | input | 8 | Register address |
| cs_n_i | input | 1 | Active-low select |
| as_n_i | input | 1 | Active-low address strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data to the bus, 0 when not enabled |
| data_oe_o | output | 1 | Output enable of the data bus |
| wait_o | output | 1 | 1 when the host may proceed |

## Verification
The hardest conditions to reach are the ones that need strobe timing which a well-behaved host never produces. These are both strobes low in the address phase, the select being dropped halfway through a stretched read, and the address lines moving after capture. Directed sequences create each of these explicitly, with inputs changed between edges so that each rising and falling sample sees a known value. After each one, a later normal read checks the register contents through the ports, so any write that slipped through would show up.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  typedef enum logic [2:0] {
    HB_IDLE  = 3'd0,
    HB_ADDR  = 3'd1,
    HB_RDATA = 3'd2,
    HB_WCAP  = 3'd3,
    HB_WHOLD = 3'd4,
    HB_END   = 3'd5
  } hb_state_e;
endpackage

// File: rtl/hb_addr_latch.sv
module hb_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_mode,
  input  logic          cs_n,
  input  logic          as_n,
  input  logic [AW-1:0] addr_in,
  input  logic          capture,
  output logic          sel,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] addr_nxt;

  // mode 0: select alone; mode 1: select qualified by address strobe
  always_comb begin
    if (addr_mode) sel = !cs_n && !as_n;
    else           sel = !cs_n;
  end

  always_comb begin
    addr_nxt = addr_q;
    if (capture) addr_nxt = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_nxt;
  end
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hostbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      rd_n,
  input  logic      wr_n,
  output hb_state_e state,
  output logic      capture,
  output logic      rd_load,
  output logic      wr_phase,
  output logic      oe,
  output logic      wait_n
);
  hb_state_e st_q, st_nxt;
  logic      rd_seen_q, rd_seen_nxt;

  // read strobe is qualified on the falling edge inside the address phase
  always_comb begin
    rd_seen_nxt = (st_q == HB_ADDR) && !rd_n && wr_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen_q <= 1'b0;
    else        rd_seen_q <= rd_seen_nxt;
  end

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      HB_IDLE:  if (sel) st_nxt = HB_ADDR;
      HB_ADDR: begin
        if (rd_seen_q)          st_nxt = HB_RDATA;
        else if (!wr_n && rd_n) st_nxt = HB_WCAP;
      end
      HB_RDATA: if (rd_n) st_nxt = HB_END;
      HB_WCAP:  st_nxt = wr_n ? HB_END : HB_WHOLD;
      HB_WHOLD: if (wr_n) st_nxt = HB_END;
      HB_END:   st_nxt = HB_END;
      default:  st_nxt = HB_IDLE;
    endcase
    if (!sel) st_nxt = HB_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HB_IDLE;
    else        st_q <= st_nxt;
  end

  always_comb begin
    state    = st_q;
    capture  = (st_q == HB_IDLE) && sel;
    rd_load  = (st_q == HB_ADDR) && rd_seen_q && sel;
    wr_phase = (st_q == HB_WCAP);
    oe       = (st_q == HB_RDATA);
    wait_n   = !((st_q == HB_ADDR) || (st_q == HB_WCAP));
  end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_phase,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int          IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

  logic [DW-1:0] mem_q [DEPTH];
  logic          in_range;
  logic [IDX_W-1:0] idx;
  logic          wr_en;

  always_comb begin
    in_range = ({1'b0, addr} < DEPTH_V);
    idx      = addr[IDX_W-1:0];
    wr_en    = wr_phase && in_range;
  end

  // storage is written on the falling edge inside the capture state
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_range) rdata = mem_q[idx];
  end
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hostbus_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic          cs_n_i,
  input  logic          as_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          wait_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          sel;
  logic [AW-1:0] addr_q;
  hb_state_e     state;
  logic          capture, rd_load, wr_phase, oe, wait_n;
  logic [DW-1:0] rdata;
  logic [DW-1:0] dout_q, dout_nxt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  hb_addr_latch #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr_mode(addr_mode_i),
    .cs_n     (cs_n_i),
    .as_n     (as_n_i),
    .addr_in  (addr_i),
    .capture  (capture),
    .sel      (sel),
    .addr_q   (addr_q)
  );

  hb_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel     (sel),
    .rd_n    (rd_n_i),
    .wr_n    (wr_n_i),
    .state   (state),
    .capture (capture),
    .rd_load (rd_load),
    .wr_phase(wr_phase),
    .oe      (oe),
    .wait_n  (wait_n)
  );

  hb_regfile #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr    (addr_q),
    .wr_phase(wr_phase),
    .wdata   (data_i),
    .rdata   (rdata)
  );

  always_comb begin
    dout_nxt = dout_q;
    if (rd_load) dout_nxt = rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) dout_q <= '0;
    else            dout_q <= dout_nxt;
  end

  always_comb begin
    data_oe_o = oe && (state == HB_RDATA);
    data_o    = data_oe_o ? dout_q : '0;
    wait_o    = wait_n;
  end
endmodule

// File: rtl/hostbus_slave_chk.sv
module hostbus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_mode_i,
  input logic cs_n_i,
  input logic as_n_i,
  input logic rd_n_i,
  input logic wr_n_i,
  input logic data_oe_o,
  input logic wait_o
);
  assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (wait_o && !data_oe_o));

  assert_strobe_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode_i && as_n_i) |=> (wait_o && !data_oe_o));

  assert_drive_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> wait_o);

  assert_read_needs_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> $past(!rd_n_i));

  assert_no_drive_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> $past(wr_n_i));

  assert_release_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && rd_n_i) |=> !data_oe_o);
endmodule

bind hostbus_slave hostbus_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_mode_i(addr_mode_i),
  .cs_n_i     (cs_n_i),
  .as_n_i     (as_n_i),
  .rd_n_i     (rd_n_i),
  .wr_n_i     (wr_n_i),
  .data_oe_o  (data_oe_o),
  .wait_o     (wait_o)
);

// File: tb/hostbus_slave_test.sv
module hostbus_slave_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_mode_i;
  logic [7:0] addr_i;
  logic       cs_n_i, as_n_i, rd_n_i, wr_n_i;
  logic [7:0] data_i;
  logic [7:0] data_o;
  logic       data_oe_o, wait_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  hostbus_slave uut (
    .clk(clk), .rst_n(rst_n), .addr_mode_i(addr_mode_i), .addr_i(addr_i),
    .cs_n_i(cs_n_i), .as_n_i(as_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .wait_o(wait_o)
  );

  // {write, addr, data, stretch}
  localparam logic [20:0] VEC [10] = '{
    {1'b1, 8'h00, 8'h5A, 4'd0},
    {1'b1, 8'h0F, 8'hC3, 4'd0},
    {1'b1, 8'h07, 8'h81, 4'd0},
    {1'b0, 8'h00, 8'h00, 4'd0},
    {1'b0, 8'h0F, 8'h00, 4'd2},
    {1'b0, 8'h07, 8'h00, 4'd1},
    {1'b1, 8'h12, 8'h99, 4'd0},
    {1'b0, 8'h12, 8'h00, 4'd0},
    {1'b0, 8'h02, 8'h00, 4'd3},
    {1'b1, 8'h10, 8'h66, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] expect_rd(input logic [7:0] a);
    return (a < 8'd16) ? model[a[3:0]] : 8'h00;
  endfunction

  task automatic go_idle;
    cs_n_i = 1'b1; as_n_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1;
  endtask

  task automatic do_read(input logic mode, input logic [7:0] a, input logic [7:0] alt,
                         input int stretch, input logic [7:0] exp, input string tag);
    addr_mode_i = mode;
    addr_i = a; cs_n_i = 1'b0; as_n_i = mode ? 1'b0 : 1'b1; rd_n_i = 1'b0;
    tick;
    chk({tag, " R4 addr phase wait"}, wait_o, 1'b0);
    chk({tag, " R4 addr phase oe"}, data_oe_o, 1'b0);
    addr_i = alt;
    tick;
    chk({tag, " R4 oe"}, data_oe_o, 1'b1);
    chk({tag, " R4 data"}, data_o, exp);
    chk({tag, " R4 wait"}, wait_o, 1'b1);
    for (int k = 0; k < stretch; k++) begin
      tick;
      chk({tag, " R5 held data"}, {data_oe_o, data_o}, {1'b1, exp});
    end
    rd_n_i = 1'b1;
    tick;
    chk({tag, " R6 released"}, {data_oe_o, wait_o}, 2'b01);
    go_idle;
    tick;
  endtask

  task automatic do_write(input logic mode, input logic [7:0] a, input logic [7:0] d,
                          input string tag);
    addr_mode_i = mode;
    addr_i = a; data_i = d; cs_n_i = 1'b0; as_n_i = mode ? 1'b0 : 1'b1; wr_n_i = 1'b0;
    tick;
    chk({tag, " R7 addr wait"}, wait_o, 1'b0);
    tick;
    chk({tag, " R7 capture wait"}, wait_o, 1'b0);
    tick;
    chk({tag, " R7 after capture wait"}, wait_o, 1'b1);
    wr_n_i = 1'b1;
    tick;
    chk({tag, " R8 end wait"}, {data_oe_o, wait_o}, 2'b01);
    go_idle;
    tick;
    if (a < 8'd16) model[a[3:0]] = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    rst_n = 1'b0; addr_mode_i = 1'b0; addr_i = 8'h00; data_i = 8'h00;
    go_idle;
    repeat (3) tick;
    chk("R1 reset wait", wait_o, 1'b1);
    chk("R1 reset oe", data_oe_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) tick;
    do_read(1'b0, 8'h05, 8'h05, 0, 8'h00, "R1 reset contents");

    for (int i = 0; i < 10; i++) begin
      logic [20:0] v;
      v = VEC[i];
      if (v[20]) do_write(i[0], v[19:12], v[11:4], "R2 R10 vec write");
      else do_read(i[0], v[19:12], v[19:12], int'(v[3:0]), expect_rd(v[19:12]), "R2 R10 vec read");
    end
    do_read(1'b0, 8'h00, 8'h00, 0, 8'h5A, "R10 alias 0x10 kept reg0");

    // R3: mode 1 with the address strobe held high
    addr_mode_i = 1'b1; addr_i = 8'h0F; cs_n_i = 1'b0; as_n_i = 1'b1; rd_n_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick;
      chk("R3 no access without strobe", {data_oe_o, wait_o}, 2'b01);
    end
    as_n_i = 1'b0;
    tick;
    chk("R3 access after strobe wait", wait_o, 1'b0);
    tick;
    chk("R3 access after strobe data", {data_oe_o, data_o}, {1'b1, 8'hC3});
    go_idle;
    tick; tick;

    // R11: address moves after capture
    do_read(1'b0, 8'h07, 8'h0F, 0, 8'h81, "R11 latched addr");

    // R9: both strobes low
    addr_mode_i = 1'b0; addr_i = 8'h03; data_i = 8'hEE;
    cs_n_i = 1'b0; rd_n_i = 1'b0; wr_n_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick;
      chk("R9 both strobes", {data_oe_o, wait_o}, 2'b00);
    end
    go_idle;
    tick;
    do_read(1'b0, 8'h03, 8'h03, 0, 8'h00, "R9 no write");

    // R12: select dropped during a stretched read
    addr_mode_i = 1'b0; addr_i = 8'h0F; cs_n_i = 1'b0; rd_n_i = 1'b0;
    tick; tick; tick;
    chk("R12 stretched oe", {data_oe_o, data_o}, {1'b1, 8'hC3});
    cs_n_i = 1'b1;
    tick;
    chk("R12 abort", {data_oe_o, wait_o}, 2'b01);
    go_idle;
    tick;
    do_write(1'b1, 8'h0A, 8'h3C, "R12 next write");
    do_read(1'b1, 8'h0A, 8'h0A, 1, 8'h3C, "R12 next read");

    // R1: reset in mid-run clears contents
    rst_n = 1'b0;
    tick;
    chk("R1 reset again", {data_oe_o, wait_o}, 2'b01);
    rst_n = 1'b1;
    repeat (3) tick;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    do_read(1'b0, 8'h0A, 8'h0A, 0, 8'h00, "R1 cleared");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule